// File: doc/BRIEF.md
# I2C Write-Only Target Byte Receiver

This block sits on a two-wire serial bus as a target device that only accepts writes. It watches the clock and data lines, recognises bus start and stop conditions, and checks whether the first byte after a start carries its own 7-bit address with the direction bit cleared. On a match it acknowledges that byte and every byte that follows. Each data byte goes to a parallel output together with a full flag and a one-cycle interrupt pulse. The address byte itself is never handed over as data.

A local consumer takes each byte and frees the buffer with a take strobe. If the bus brings in another byte while the buffer is still occupied, the receiver raises an overflow flag. It then holds the clock line low until the consumer frees the buffer, and only after that does it accept and acknowledge the new byte. Two status flags show whether a start or a stop was seen last, so a master that shares the same pins can tell whether the bus is busy. A third flag shows whether the most recent byte the receiver accepted was an address or data.

Top module: `i2c_wr_target`

## Requirements
- R1: While reset is high and in the first cycle after it, both pull outputs are 0 and rx_full, rx_irq, rx_ovf, last_was_addr, seen_start and seen_stop are all 0.
- R2: A falling data edge while the clock is high (start) sets seen_start to 1 and seen_stop to 0. A rising data edge while the clock is high (stop) sets seen_stop to 1 and seen_start to 0. The two flags are never 1 together.
- R3: The first byte after a start is sent MSB first, with the address in bits 7..1 and the direction in bit 0 (0 = write). If bits 7..1 equal dev_addr and bit 0 is 0, the receiver pulls data low during the ninth clock and sets last_was_addr. rx_full and rx_data do not change.
- R4: If the address does not match, or bit 0 is 1, the receiver does not acknowledge. All following bytes are then ignored, with no acknowledge, no change to rx_full and no interrupt, until the next start.
- R5: After an acknowledged address, each data byte is assembled MSB first and appears on rx_data with rx_full set to 1 and last_was_addr cleared, and it is acknowledged in the ninth clock.
- R6: A one-cycle rx_take pulse clears rx_full.
- R7: If a data byte completes while rx_full is still 1, rx_ovf goes to 1, the clock line is held low and rx_data keeps the old byte. A take then loads the new byte, clears rx_ovf, releases the clock and acknowledges the byte.
- R8: A repeated start in the middle of a byte discards the partial bits and returns to address matching.
- R9: The data line is released once the acknowledge clock ends, and the data line and clock line are never pulled at the same time.
- R10: rx_irq is a single-cycle pulse, raised exactly once for each byte loaded into rx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 7 | Own 7-bit bus address |
| scl_in | input | 1 | Clock line level as seen at the pin |
| sda_in | input | 1 | Data line level as seen at the pin |
| scl_pull | output | 1 | 1 = drive clock line low (open-drain) |
| sda_pull | output | 1 | 1 = drive data line low (open-drain) |
| rx_data | output | 8 | Last delivered data byte |
| rx_full | output | 1 | Buffer holds an untaken byte |
| rx_irq | output | 1 | One-cycle pulse when a byte is delivered |
| rx_take | input | 1 | Consumer frees the buffer |
| rx_ovf | output | 1 | A byte is waiting while the buffer is full |
| last_was_addr | output | 1 | Most recent accepted byte was an address |
| seen_start | output | 1 | Start seen more recently than stop |
| seen_stop | output | 1 | Stop seen more recently than start |

## Verification
A wrong bit counter or a wrong shift shows up within one byte time. The acknowledge lands in the wrong clock, or rx_data holds a rotated value when the ninth clock ends. A wrong state after an address mismatch, a repeated start or an overflow shows up as an acknowledge where none belongs, or as a missing one, before the next byte finishes. It also shows up in the interrupt count. A mistake in the clock hold shows as a bus that stalls past the take strobe or never stalls, and rx_ovf and scl_pull can be seen at the pins during the stall itself.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ACK_A,
    RX_DATA,
    RX_ACK_D,
    RX_HOLD,
    RX_SKIP
  } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              rx_take,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic [ADDR_W:0]   rx_data,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              rx_ovf,
  output logic              last_was_addr
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(BYTE_W);

  rx_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              shifting;
  logic              byte_done;

  assign shifting  = (state == RX_ADDR || state == RX_DATA);
  assign byte_done = shifting && scl_fall && (bit_cnt == CNT_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= RX_IDLE;
      bit_cnt       <= '0;
      shreg         <= '0;
      scl_pull      <= 1'b0;
      sda_pull      <= 1'b0;
      rx_data       <= '0;
      rx_full       <= 1'b0;
      rx_irq        <= 1'b0;
      rx_ovf        <= 1'b0;
      last_was_addr <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (rx_take) begin
        rx_full <= 1'b0;
        rx_ovf  <= 1'b0;
      end

      if (start_ev) begin
        state    <= RX_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        scl_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= RX_IDLE;
        sda_pull <= 1'b0;
        scl_pull <= 1'b0;
      end else begin
        if (shifting && scl_rise && bit_cnt != CNT_DONE) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
        case (state)
          RX_ADDR: begin
            if (byte_done) begin
              if (shreg[BYTE_W-1:1] == dev_addr && !shreg[0]) begin
                sda_pull      <= 1'b1;
                last_was_addr <= 1'b1;
                state         <= RX_ACK_A;
              end else begin
                state <= RX_SKIP;
              end
            end
          end
          RX_ACK_A, RX_ACK_D: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= RX_DATA;
            end
          end
          RX_DATA: begin
            if (byte_done) begin
              if (!rx_full || rx_take) begin
                rx_data       <= shreg;
                rx_full       <= 1'b1;
                rx_irq        <= 1'b1;
                last_was_addr <= 1'b0;
                sda_pull      <= 1'b1;
                state         <= RX_ACK_D;
              end else begin
                rx_ovf   <= 1'b1;
                scl_pull <= 1'b1;
                state    <= RX_HOLD;
              end
            end
          end
          RX_HOLD: begin
            if (rx_take) begin
              rx_data       <= shreg;
              rx_full       <= 1'b1;
              rx_irq        <= 1'b1;
              last_was_addr <= 1'b0;
              scl_pull      <= 1'b0;
              sda_pull      <= 1'b1;
              state         <= RX_ACK_D;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic [ADDR_W:0]   rx_data,
  output logic              rx_full,
  output logic              rx_irq,
  input  logic              rx_take,
  output logic              rx_ovf,
  output logic              last_was_addr,
  output logic              seen_start,
  output logic              seen_stop
);
  logic [1:0] pins_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) sync_i (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(pins_s)
  );

  i2c_bus_events ev_i (
    .clk(clk), .rst(rst), .scl_s(pins_s[1]), .sda_s(pins_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_rx_engine #(.ADDR_W(ADDR_W)) eng_i (
    .clk(clk), .rst(rst), .dev_addr(dev_addr), .sda_s(pins_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .rx_take(rx_take),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .rx_data(rx_data),
    .rx_full(rx_full), .rx_irq(rx_irq), .rx_ovf(rx_ovf),
    .last_was_addr(last_was_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_start <= 1'b0;
      seen_stop  <= 1'b0;
    end else if (start_ev) begin
      seen_start <= 1'b1;
      seen_stop  <= 1'b0;
    end else if (stop_ev) begin
      seen_start <= 1'b0;
      seen_stop  <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rx_chk.sv
module i2c_rx_chk (
  input logic clk,
  input logic rst,
  input logic scl_pull,
  input logic sda_pull,
  input logic rx_full,
  input logic rx_irq,
  input logic rx_ovf,
  input logic seen_start,
  input logic seen_stop
);
  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);
  // R5
  irq_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);
  // R2
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(seen_start && seen_stop));
  // R7
  stretch_full_chk: assert property (@(posedge clk) disable iff (rst)
    scl_pull |-> (rx_full && rx_ovf));
  // R7
  ovf_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf) |-> scl_pull);
  // R9
  pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(scl_pull && sda_pull));
endmodule

bind i2c_wr_target i2c_rx_chk chk_i (
  .clk(clk), .rst(rst), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .rx_full(rx_full), .rx_irq(rx_irq), .rx_ovf(rx_ovf),
  .seen_start(seen_start), .seen_stop(seen_stop)
);

// File: tb/i2c_wr_target_tb.sv
module i2c_wr_target_tb_top;
  localparam int H = 10;
  localparam logic [6:0] MY_ADDR = 7'h51;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic rx_take = 1'b0;
  logic scl_pull, sda_pull, rx_full, rx_irq, rx_ovf;
  logic last_was_addr, seen_start, seen_stop;
  logic [7:0] rx_data;
  wire scl_line = scl_m & ~scl_pull;
  wire sda_line = sda_m & ~sda_pull;

  int tests = 0;
  int fails = 0;
  int irq_cnt = 0;

  always #10 clk = ~clk;

  i2c_wr_target dut_i (
    .clk(clk), .rst(rst), .dev_addr(MY_ADDR), .scl_in(scl_line),
    .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
    .rx_take(rx_take), .rx_ovf(rx_ovf), .last_was_addr(last_was_addr),
    .seen_start(seen_start), .seen_stop(seen_stop)
  );

  always @(posedge clk) if (!rst && rx_irq) irq_cnt <= irq_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic bit_out(input logic b, output logic rd);
    sda_m = b; wait_clk(H);
    scl_m = 1'b1; wait_clk(1);
    while (!scl_line) wait_clk(1);
    wait_clk(H/2);
    rd = sda_line;
    wait_clk(H/2);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) bit_out(b[i], d);
    bit_out(1'b1, d);
    ack = ~d;
  endtask

  task automatic pulse_take();
    rx_take = 1'b1; wait_clk(1);
    rx_take = 1'b0; wait_clk(1);
  endtask

  task automatic t_reset();
    check("R1 scl_pull", scl_pull, 0);
    check("R1 sda_pull", sda_pull, 0);
    check("R1 flags", {rx_full, rx_irq, rx_ovf, last_was_addr, seen_start, seen_stop}, 0);
  endtask

  task automatic t_write_one();
    logic ack;
    int n0 = irq_cnt;
    bus_start();
    check("R2 start flags", {seen_start, seen_stop}, 2'b10);
    send_byte(8'hA2, ack);
    check("R3 address ack", ack, 1);
    check("R3 last_was_addr", last_was_addr, 1);
    check("R3 no delivery", rx_full, 0);
    send_byte(8'h3C, ack);
    check("R5 data ack", ack, 1);
    check("R5 rx_data", rx_data, 8'h3C);
    check("R5 rx_full", rx_full, 1);
    check("R5 kind data", last_was_addr, 0);
    check("R10 one irq", irq_cnt - n0, 1);
    check("R9 sda released", sda_pull, 0);
    bus_stop();
    check("R2 stop flags", {seen_start, seen_stop}, 2'b01);
  endtask

  task automatic t_take();
    pulse_take();
    check("R6 full cleared", rx_full, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    int n0 = irq_cnt;
    bus_start();
    send_byte(8'hA4, ack);
    check("R4 other address nack", ack, 0);
    send_byte(8'h55, ack);
    check("R4 data ignored nack", ack, 0);
    check("R4 no delivery", rx_full, 0);
    check("R4 no irq", irq_cnt - n0, 0);
    bus_start();
    send_byte(8'hA3, ack);
    check("R4 read bit nack", ack, 0);
    send_byte(8'h66, ack);
    check("R4 read ignored", {ack, rx_full}, 0);
    bus_stop();
  endtask

  task automatic t_overflow();
    logic ack;
    int n0 = irq_cnt;
    bus_start();
    send_byte(8'hA2, ack);
    send_byte(8'h11, ack);
    check("R5 first byte", rx_data, 8'h11);
    fork
      send_byte(8'h22, ack);
      begin
        while (!scl_pull) wait_clk(1);
        wait_clk(2);
        check("R7 ovf set", rx_ovf, 1);
        check("R7 old data kept", rx_data, 8'h11);
        wait_clk(60);
        check("R7 clock held", scl_line, 0);
        pulse_take();
      end
    join
    check("R7 ack after take", ack, 1);
    check("R7 new data", rx_data, 8'h22);
    check("R7 full and ovf", {rx_full, rx_ovf}, 2'b10);
    check("R10 irq per byte", irq_cnt - n0, 2);
    bus_stop();
    pulse_take();
  endtask

  task automatic t_rstart();
    logic ack, d;
    int n0 = irq_cnt;
    bus_start();
    send_byte(8'hA2, ack);
    bit_out(1'b1, d); bit_out(1'b0, d); bit_out(1'b1, d); bit_out(1'b0, d);
    bus_start();
    check("R2 restart flags", {seen_start, seen_stop}, 2'b10);
    send_byte(8'hA2, ack);
    check("R8 readdressed ack", ack, 1);
    check("R8 partial dropped", {rx_full, irq_cnt - n0}, 0);
    send_byte(8'h5A, ack);
    check("R8 data after restart", rx_data, 8'h5A);
    check("R8 single irq", irq_cnt - n0, 1);
    bus_stop();
    pulse_take();
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    rst = 1'b0;
    wait_clk(1);
    t_reset();
    wait_clk(H);
    t_write_one();
    t_take();
    t_mismatch();
    t_overflow();
    t_rstart();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule